// File: doc/BRIEF.md
# NAND Flash Strobe Sequencer

This block turns single-byte host accesses into the cycles of a raw 8-bit NAND flash bus. The host port is a valid/ready request channel. The address decides what kind of flash cycle to run, so software picks a cycle type by choosing an address and needs no mode register. A byte sent to the data window is a plain data transfer. A byte sent to the command window is latched by the flash as a command. A byte sent to the address window is latched as an address byte. Each flash cycle has one setup clock, then a write or read strobe held low for a programmable number of clocks, then one hold clock.

A small register space sits beside the flash windows. It holds the chip-select control register and a status register. The status register reports the flash ready/busy line after a two-flop synchroniser. Each chip has two bits in the control register: an enable bit and an assert bit. The chip-enable pin of a chip goes active only when both of its bits are set.

Back-pressure rules: a request is taken when `req_valid` and `req_ready` are both high on a rising clock edge. While `req_valid` is high and `req_ready` is low, the host must hold the address, direction and write data stable. A flash-window request keeps `req_ready` low until the flash cycle reaches its hold clock. A register request is ready in the same cycle, provided no flash cycle is running. `rd_data` is valid in the cycle where a read is accepted.

Top module: `nand_strobe_ctl`

## Requirements
- R1: An access with address bits [16:15] = 00 and address bit 17 = 0 runs a data cycle. CLE and ALE stay low for the whole cycle, and a write drives the host byte on `nand_io_out`.
- R2: An access with bit 15 = 1, bit 16 = 0 and bit 17 = 0 (offset 0x08000) runs a command cycle. CLE is high and ALE is low from the setup clock through the hold clock, and neither changes on the clock where the strobe falls.
- R3: An access with bit 16 = 1 and bit 17 = 0 (offsets 0x10000 and 0x18000) runs an address cycle, with ALE high and CLE low. CLE and ALE are never high together.
- R4: The control register is at offset 0x20000, with bit 2 = 0. Bit 2n is the enable bit of chip n and bit 2n+1 is its assert bit. `nand_ce_n[n]` is low exactly when both bits are set. The register reads back as written. After reset it is 0 and every `nand_ce_n` bit is high.
- R5: A flash write has one setup clock, then `nand_we_n` low for STROBE_CYC clocks (3 by default), then one hold clock. `nand_io_oe` is high from setup through hold, and `nand_re_n` stays high.
- R6: A flash read holds `nand_re_n` low for STROBE_CYC clocks. The block captures `nand_io_in` at the clock edge where `nand_re_n` rises and returns that byte on `rd_data` when the read is accepted. `nand_we_n` stays high.
- R7: For a flash access, `req_ready` is low until the hold clock. If a request is first seen in an idle cycle, `req_ready` rises STROBE_CYC+2 cycles later. During that hold cycle no strobe is low.
- R8: The status register is at offset 0x20004, with bit 2 = 1. Bit 0 returns `nand_rb` delayed by two clocks. A change on `nand_rb` is not visible one clock later. Writes to the status register change no state.
- R9: Register reads and writes complete in the cycle they are presented (`req_ready` high at once) when no flash cycle is running, and they produce no flash strobe.
- R10: When no flash cycle is running, CLE and ALE are low, both strobes are high and `nand_io_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted / access complete |
| req_addr | input | ADDR_W (18) | Host byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (8) | Write byte |
| rd_data | output | DATA_W (8) | Read byte, valid with read acceptance |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NUM_CHIPS (2) | Per-chip enable, active low |
| nand_io_out | output | DATA_W (8) | Flash data bus, outbound |
| nand_io_oe | output | 1 | Flash data bus drive enable |
| nand_io_in | input | DATA_W (8) | Flash data bus, inbound |
| nand_rb | input | 1 | Flash ready (1) / busy (0), asynchronous |

## Verification
The hardest cases to reach are those tied to timing. One is the edge where a read strobe rises and the returned byte is captured. Another is two flash accesses that follow each other with no idle cycle between them, which tests whether CLE, ALE and the strobes stay clean across the change of cycle kind. The stimulus sends command, address and data bytes one after another through the host task and changes `nand_io_in` for each read. A monitor queues every falling strobe together with the CLE/ALE state and the bus value seen at that moment, and measures how long each strobe stays low. Reading the status register on the very next clock after `nand_rb` changes checks the synchroniser delay from the ports.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

  // The address-latch window wins over the command window, so the two
  // latch enables can never be raised together.
  function automatic cyc_kind_e decode_kind(input logic cmd_bit, input logic adr_bit);
    if (adr_bit)      return CYC_ADDR;
    else if (cmd_bit) return CYC_CMD;
    else              return CYC_DATA;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nand_ce_reg.sv
module nand_ce_reg #(
  parameter int NUM_CHIPS = 2,
  localparam int CTRL_W = 2 * NUM_CHIPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NUM_CHIPS-1:0] ce_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
    assign ce_n[g] = ~(ctrl_q[2*g] & ctrl_q[2*g+1]);
  end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 3,
  localparam int CNT_W     = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  cyc_kind_e         start_kind,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [DATA_W-1:0] io_in,
  output seq_state_e        state,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] io_out,
  output logic              io_oe
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

  seq_state_e        state_q;
  cyc_kind_e         kind_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= CYC_DATA;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            kind_q  <= start_kind;
            wr_q    <= start_write;
            wdata_q <= start_wdata;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt_q   <= CNT_LOAD;
          state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            state_q <= ST_HOLD;
            if (!wr_q) rdata_q <= io_in;  // captured as RE rises
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;  // ST_HOLD
      endcase
    end
  end

  logic active;
  assign active = (state_q != ST_IDLE);

  assign state  = state_q;
  assign done   = (state_q == ST_HOLD);
  assign rdata  = rdata_q;
  assign cle    = active && (kind_q == CYC_CMD);
  assign ale    = active && (kind_q == CYC_ADDR);
  assign we_n   = !((state_q == ST_STROBE) && wr_q);
  assign re_n   = !((state_q == ST_STROBE) && !wr_q);
  assign io_out = wdata_q;
  assign io_oe  = active && wr_q;
endmodule

// File: rtl/nand_strobe_ctl.sv
module nand_strobe_ctl
  import nand_strobe_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int NUM_CHIPS   = 2,
  parameter int STROBE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic                 nand_re_n,
  output logic [NUM_CHIPS-1:0] nand_ce_n,
  output logic [DATA_W-1:0]    nand_io_out,
  output logic                 nand_io_oe,
  input  logic [DATA_W-1:0]    nand_io_in,
  input  logic                 nand_rb
);
  localparam int CTRL_W   = 2 * NUM_CHIPS;
  localparam int CMD_BIT  = 15;
  localparam int ADR_BIT  = 16;
  localparam int REG_BIT  = ADDR_W - 1;
  localparam int STAT_BIT = 2;
  localparam logic [ADDR_W-1:0] USED_MASK =
    ADDR_W'((1 << CMD_BIT) | (1 << ADR_BIT) | (1 << REG_BIT) | (1 << STAT_BIT));

  logic is_reg, is_stat, idle, start, ctrl_wr, rdy_sync;
  logic unused_addr_bits;
  seq_state_e        seq_state;
  logic              seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] reg_rdata;

  assign unused_addr_bits = ^(req_addr & ~USED_MASK);

  assign is_reg  = req_addr[REG_BIT];
  assign is_stat = req_addr[STAT_BIT];
  assign idle    = (seq_state == ST_IDLE);
  assign start   = req_valid && !is_reg && idle;

  assign req_ready = (idle && is_reg) || seq_done;
  assign ctrl_wr   = req_valid && req_ready && is_reg && !is_stat && req_write;

  assign reg_rdata = is_stat ? DATA_W'(rdy_sync) : DATA_W'(ctrl_q);
  assign rd_data   = is_reg ? reg_rdata : seq_rdata;

  nand_cycle_seq #(
    .DATA_W    (DATA_W),
    .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_write(req_write),
    .start_kind (decode_kind(req_addr[CMD_BIT], req_addr[ADR_BIT])),
    .start_wdata(req_wdata),
    .io_in      (nand_io_in),
    .state      (seq_state),
    .done       (seq_done),
    .rdata      (seq_rdata),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .io_out     (nand_io_out),
    .io_oe      (nand_io_oe)
  );

  nand_ce_reg #(
    .NUM_CHIPS(NUM_CHIPS)
  ) u_ce (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wr_data(req_wdata[CTRL_W-1:0]),
    .ctrl_q (ctrl_q),
    .ce_n   (nand_ce_n)
  );

  nand_rb_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(nand_rb),
    .sync_out(rdy_sync)
  );
endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk #(
  parameter int NUM_CHIPS  = 2,
  parameter int STROBE_CYC = 3,
  localparam int CW = $clog2(STROBE_CYC + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cle,
  input logic                   ale,
  input logic                   we_n,
  input logic                   re_n,
  input logic                   io_oe,
  input logic                   req_ready,
  input logic [NUM_CHIPS-1:0]   ce_n,
  input logic [2*NUM_CHIPS-1:0] ctrl_q
);
  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              lo_cnt <= '0;
    else if (!we_n || !re_n) lo_cnt <= lo_cnt + 1'b1;
    else                     lo_cnt <= '0;
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R5
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> io_oe); // R5
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n) lo_cnt <= CW'(STROBE_CYC)); // R6
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |-> lo_cnt == CW'(STROBE_CYC)); // R5
  AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> ($stable(cle) && $stable(ale))); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (we_n && re_n)); // R7

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_ce
    AST_CE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n[g] |-> (ctrl_q[2*g] && ctrl_q[2*g+1])); // R4
  end
endmodule

bind nand_strobe_ctl nand_strobe_chk #(
  .NUM_CHIPS (NUM_CHIPS),
  .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cle      (nand_cle),
  .ale      (nand_ale),
  .we_n     (nand_we_n),
  .re_n     (nand_re_n),
  .io_oe    (nand_io_oe),
  .req_ready(req_ready),
  .ce_n     (nand_ce_n),
  .ctrl_q   (ctrl_q)
);

// File: tb/test_nand_strobe_ctl.sv
`timescale 1ns/1ps
module test_nand_strobe_ctl;
  localparam int ADDR_W = 18;
  localparam int STROBE = 3;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       wr;
    logic [7:0] data;
  } bus_ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rd_data;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [1:0] nand_ce_n;
  logic [7:0] nand_io_out;
  logic [7:0] nand_io_in = '0;
  logic nand_rb = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bus_ev_t exp_q[$];

  always #4 clk = ~clk;

  nand_strobe_ctl i_nand_strobe_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rd_data(rd_data),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: one host access; returns the read byte and cycles until ready.
  task automatic host(input logic [ADDR_W-1:0] a, input logic w, input logic [7:0] d,
                      output logic [7:0] rdata, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    lat = 0;
    forever begin
      #1;
      if (req_ready) begin rdata = rd_data; break; end
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic flash_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          input logic c, input logic l, input string req);
    logic [7:0] r; int lat;
    exp_q.push_back('{cle: c, ale: l, wr: 1'b1, data: d});
    host(a, 1'b1, d, r, lat);
    chk({req, " write latency"}, lat, STROBE + 2);
  endtask

  task automatic flash_rd(input logic [ADDR_W-1:0] a, input logic [7:0] fdata,
                          input logic c, input logic l, input string req);
    logic [7:0] r; int lat;
    nand_io_in = fdata;
    exp_q.push_back('{cle: c, ale: l, wr: 1'b0, data: 8'h00});
    host(a, 1'b0, 8'h00, r, lat);
    chk({req, " read data"}, r, fdata);
    chk("R7 read latency", lat, STROBE + 2);
  endtask

  // Monitor: pops an expected item at every falling strobe and times the pulse.
  logic prev_we = 1'b1, prev_re = 1'b1;
  int lo_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected strobe", 1, 0);
        end else begin
          bus_ev_t e;
          e = exp_q.pop_front();
          chk("R2 cle at strobe", nand_cle, e.cle);
          chk("R3 ale at strobe", nand_ale, e.ale);
          chk("R5 we vs re", !nand_we_n, e.wr);
          if (e.wr) begin
            chk("R1 bus data", nand_io_out, e.data);
            chk("R5 bus driven", nand_io_oe, 1'b1);
          end
        end
      end
      if (!nand_we_n || !nand_re_n) lo_len++;
      else if (lo_len != 0) begin
        chk("R5 strobe width", lo_len, STROBE);
        lo_len = 0;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; int lat;
    repeat (4) @(negedge clk);
    chk("R10 reset cle/ale", {nand_cle, nand_ale}, 2'b00);
    chk("R10 reset strobes", {nand_we_n, nand_re_n, nand_io_oe}, 3'b110);
    chk("R4 reset ce_n", nand_ce_n, 2'b11);
    rst_n = 1'b1;

    host(18'h20000, 1'b0, 8'h00, r, lat);
    chk("R4 ctrl reset value", r, 8'h00);
    chk("R9 register latency", lat, 0);

    flash_wr(18'h00000, 8'hA5, 1'b0, 1'b0, "R1");
    flash_wr(18'h08000, 8'h70, 1'b1, 1'b0, "R2");
    flash_wr(18'h10000, 8'h12, 1'b0, 1'b1, "R3");
    flash_wr(18'h18000, 8'h34, 1'b0, 1'b1, "R3");
    flash_rd(18'h00000, 8'h3C, 1'b0, 1'b0, "R6");
    flash_rd(18'h08000, 8'hC3, 1'b1, 1'b0, "R6");
    flash_rd(18'h10000, 8'h5A, 1'b0, 1'b1, "R6");
    @(negedge clk);
    chk("R10 idle pins", {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe}, 5'b00110);

    host(18'h20000, 1'b1, 8'h01, r, lat);
    chk("R4 enable only", nand_ce_n, 2'b11);
    host(18'h20000, 1'b1, 8'h02, r, lat);
    chk("R4 assert only", nand_ce_n, 2'b11);
    host(18'h20000, 1'b1, 8'h03, r, lat);
    chk("R4 chip0 active", nand_ce_n, 2'b10);
    host(18'h20000, 1'b1, 8'h0C, r, lat);
    chk("R4 chip1 active", nand_ce_n, 2'b01);
    host(18'h20000, 1'b1, 8'h0F, r, lat);
    chk("R4 both active", nand_ce_n, 2'b00);
    host(18'h20000, 1'b0, 8'h00, r, lat);
    chk("R4 readback", r, 8'h0F);

    host(18'h20004, 1'b0, 8'h00, r, lat);
    chk("R8 busy seen", r, 8'h00);
    nand_rb = 1'b1;
    host(18'h20004, 1'b0, 8'h00, r, lat);
    chk("R8 sync delay", r, 8'h00);
    host(18'h20004, 1'b0, 8'h00, r, lat);
    chk("R8 ready seen", r, 8'h01);
    host(18'h20004, 1'b1, 8'h00, r, lat);
    host(18'h20000, 1'b0, 8'h00, r, lat);
    chk("R8 status write ignored ctrl", r, 8'h0F);
    host(18'h20004, 1'b0, 8'h00, r, lat);
    chk("R8 status write ignored rdy", r, 8'h01);

    flash_wr(18'h08000, 8'h80, 1'b1, 1'b0, "R2");
    flash_wr(18'h10000, 8'h00, 1'b0, 1'b1, "R3");
    flash_wr(18'h00000, 8'hFF, 1'b0, 1'b0, "R1");

    repeat (3) @(negedge clk);
    chk("R5 all strobes matched", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule